// File: doc/BRIEF.md
# Instruction Cache Parity Scrubber

This block inspects one set of a four-way instruction cache and reports whether any of the stored parity is inconsistent. A start strobe captures a set index and a data-check enable. The block then walks the ways in order. For each way it reads the tag through a synchronous read port. When data checking is enabled, it also reads the four instruction doublewords of that line. Every returned word is checked against its parity fields on the cycle it arrives.

Tag and data faults are gathered separately, both per way and as two flags in a 32-bit result word. The replacement-order field of way 0 is decoded into four 2-bit way numbers. A single-cycle done pulse marks the end of the walk. All results then stay frozen until the next accepted start, so a handler can read them at leisure.

The read port takes one request per cycle and returns the data on the cycle after the request. A tag read returns a 32-bit high word and a 64-bit low word. A data read returns a 32-bit high word carrying the check bits, and a 64-bit low word whose upper half is instruction A and whose lower half is instruction B.

Top module: `icache_parity_scrubber`

## Requirements
- R1: After an accepted start, the block issues exactly one read per cycle, with no gaps, in this order. For each way w, from 0 to 3, it first issues a tag read at address {w, index}. When data checking is enabled, the four data reads of that way follow at {w, index | (k << 3)}, for k from 0 to 3. `rd_is_data_o` is 1 only on the data reads.
- R2: For every way, a tag-parity fault is raised when tag-high bit 27 differs from tag-high bit 29 (the valid bit), whether or not the line is valid.
- R3: When tag-high bit 29 is 1, two more checks apply, and either mismatch is a tag-parity fault. Tag-low bit 10 must equal the XOR of tag-low bits 23:0 with bits 11 and 10 excluded. Tag-low bit 11 must equal the XOR of tag-low bits 63:24. When bit 29 is 0, these two checks are ignored.
- R4: On every data read, a data-parity fault is raised when data-high bit 16 differs from the XOR of data-high bits 15:8.
- R5: On every data read, data-high bits 7:4 must equal the even byte parity of instruction A, and data-high bits 3:0 must equal that of instruction B. Nibble bit i is the XOR of instruction bits 8i+7 down to 8i. Any difference is a data-parity fault.
- R6: `way_tag_err_o[w]` and `way_data_err_o[w]` are set when way w produced the corresponding fault. `result_o` bit 29 is the OR of all tag faults, bit 28 is the OR of all data faults, and every other result bit is 0.
- R7: `lru_order_o` equals tag-high bits 21:14 of way 0 only. Entry k occupies bits 2k+1:2k, and entry 0 is the least recently used way.
- R8: With data checking disabled, no data read is issued and no data fault is reported, even if the data array holds bad parity.
- R9: `done_o` is a one-cycle pulse. It is high in the cycle after the (N+1)-th rising edge that follows the edge sampling the start, where N is 20 reads with data checking and 4 without. All outputs hold from then until the next accepted start, and a start raised during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk; accepted only while idle |
| index_i | input | 13 | Set index captured at start |
| check_data_i | input | 1 | Also read and check the data doublewords |
| rd_req_o | output | 1 | Read request to the cache arrays |
| rd_is_data_o | output | 1 | 1 for a data read, 0 for a tag read |
| rd_addr_o | output | 15 | Read address, way in the top two bits |
| rd_hi_i | input | 32 | Returned high word, one cycle after the request |
| rd_lo_i | input | 64 | Returned low word, one cycle after the request |
| way_tag_err_o | output | 4 | Tag-parity fault per way |
| way_data_err_o | output | 4 | Data-parity fault per way |
| lru_order_o | output | 8 | Four 2-bit way numbers, least recently used way in bits 1:0 |
| done_o | output | 1 | End-of-walk pulse |
| result_o | output | 32 | Bit 29 is the tag fault, bit 28 the data fault |

## Verification
A walk of N reads ends with done in the cycle after the (N+1)-th rising edge following the start edge. The extra edge covers the port latency and the registering of the last check. The bench samples on falling edges and counts them from the start strobe, so done must appear on falling edge N+2: 22 with data checking and 6 without. Results are compared only after that pulse and again several idle cycles later, which also shows that they hold. The read addresses are logged on each rising edge and compared in order with the sequence that R1 sets out.

// File: rtl/ips_pkg.sv
package ips_pkg;
  // Bit positions that the cache arrays define and the walk decodes
  localparam int VALID_BIT     = 29;
  localparam int VALID_PAR_BIT = 27;
  localparam int TAG_SPLIT     = 24;
  localparam int TAG_PAR0_BIT  = 10;
  localparam int TAG_PAR1_BIT  = 11;
  localparam int LRU_LSB       = 14;
  localparam int PRE_LSB       = 8;
  localparam int PRE_PAR_BIT   = 16;
  localparam int RES_W         = 32;
  localparam int RES_TAG_BIT   = 29;
  localparam int RES_DATA_BIT  = 28;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_DRAIN = 2'd2
  } walk_state_e;
endpackage

// File: rtl/ips_rst_sync.sv
module ips_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ips_tag_check.sv
module ips_tag_check #(
  parameter int HI_W = 32,
  parameter int LO_W = 64
) (
  input  logic [HI_W-1:0] hi_i,
  input  logic [LO_W-1:0] lo_i,
  output logic            err_o
);
  import ips_pkg::*;

  localparam logic [TAG_SPLIT-1:0] LOW_MASK =
    ~((TAG_SPLIT'(1) << TAG_PAR0_BIT) | (TAG_SPLIT'(1) << TAG_PAR1_BIT));

  logic line_valid;
  logic valid_copy_bad;
  logic low_par;
  logic high_par;
  logic split_bad;
  logic unused_hi;

  assign line_valid     = hi_i[VALID_BIT];
  assign valid_copy_bad = hi_i[VALID_BIT] ^ hi_i[VALID_PAR_BIT];
  assign low_par        = ^(lo_i[TAG_SPLIT-1:0] & LOW_MASK);
  assign high_par       = ^lo_i[LO_W-1:TAG_SPLIT];
  assign split_bad      = (lo_i[TAG_PAR0_BIT] ^ low_par) |
                          (lo_i[TAG_PAR1_BIT] ^ high_par);
  assign err_o          = valid_copy_bad | (line_valid & split_bad);
  assign unused_hi      = ^hi_i;
endmodule

// File: rtl/ips_data_check.sv
module ips_data_check #(
  parameter int HI_W = 32,
  parameter int LO_W = 64
) (
  input  logic [HI_W-1:0] hi_i,
  input  logic [LO_W-1:0] lo_i,
  output logic            err_o
);
  import ips_pkg::*;

  localparam int INST_W = LO_W / 2;
  localparam int NBYTES = INST_W / 8;

  logic [INST_W-1:0] inst_a;
  logic [INST_W-1:0] inst_b;
  logic [NBYTES-1:0] par_a;
  logic [NBYTES-1:0] par_b;
  logic              pre_bad;
  logic              unused_hi;

  assign inst_a = lo_i[LO_W-1:INST_W];
  assign inst_b = lo_i[INST_W-1:0];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign par_a[b] = ^inst_a[8*b +: 8];
    assign par_b[b] = ^inst_b[8*b +: 8];
  end

  assign pre_bad   = hi_i[PRE_PAR_BIT] ^ (^hi_i[PRE_LSB +: 8]);
  assign err_o     = pre_bad |
                     (par_a != hi_i[2*NBYTES-1:NBYTES]) |
                     (par_b != hi_i[NBYTES-1:0]);
  assign unused_hi = ^hi_i;
endmodule

// File: rtl/ips_seq.sv
module ips_seq #(
  parameter int WAYS      = 4,
  parameter int LINE_DW   = 4,
  parameter int IDX_W     = 13,
  parameter int OFF_SHIFT = 3,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int OFF_W    = $clog2(LINE_DW),
  localparam int ADDR_W   = IDX_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic              check_data_i,
  output logic              rd_req_o,
  output logic              rd_is_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              accept_o,
  output logic              busy_o,
  output logic              pend_valid_o,
  output logic              pend_is_data_o,
  output logic [WAY_W-1:0]  pend_way_o,
  output logic              pend_last_o
);
  import ips_pkg::*;

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_DW - 1);

  walk_state_e       state_q, state_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              ph_q, ph_d;
  logic [IDX_W-1:0]  index_q, index_d;
  logic              cd_q, cd_d;
  logic              last_item;
  logic              walk_en;
  logic              pend_valid_q;
  logic              pend_data_q;
  logic [WAY_W-1:0]  pend_way_q;
  logic              pend_last_q;

  always_comb begin
    state_d   = state_q;
    way_d     = way_q;
    off_d     = off_q;
    ph_d      = ph_q;
    index_d   = index_q;
    cd_d      = cd_q;
    rd_req_o  = 1'b0;
    last_item = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_ISSUE;
          way_d   = '0;
          off_d   = '0;
          ph_d    = 1'b0;
          index_d = index_i;
          cd_d    = check_data_i;
        end
      end
      S_ISSUE: begin
        rd_req_o  = 1'b1;
        last_item = (way_q == LAST_WAY) &&
                    (ph_q ? (off_q == LAST_OFF) : !cd_q);
        if (!ph_q) begin
          if (cd_q) begin
            ph_d  = 1'b1;
            off_d = '0;
          end else begin
            way_d = way_q + 1'b1;
          end
        end else if (off_q == LAST_OFF) begin
          ph_d  = 1'b0;
          way_d = way_q + 1'b1;
        end else begin
          off_d = off_q + 1'b1;
        end
        if (last_item) state_d = S_DRAIN;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign walk_en = (state_q != S_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      way_q   <= '0;
      off_q   <= '0;
      ph_q    <= 1'b0;
      index_q <= '0;
      cd_q    <= 1'b0;
    end else if (walk_en) begin
      state_q <= state_d;
      way_q   <= way_d;
      off_q   <= off_d;
      ph_q    <= ph_d;
      index_q <= index_d;
      cd_q    <= cd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_data_q  <= 1'b0;
      pend_way_q   <= '0;
      pend_last_q  <= 1'b0;
    end else begin
      pend_valid_q <= rd_req_o;
      if (rd_req_o) begin
        pend_data_q <= ph_q;
        pend_way_q  <= way_q;
        pend_last_q <= last_item;
      end
    end
  end

  assign rd_is_data_o   = rd_req_o & ph_q;
  assign rd_addr_o      = {way_q, ph_q ? (index_q | (IDX_W'(off_q) << OFF_SHIFT))
                                       : index_q};
  assign accept_o       = (state_q == S_IDLE) && start_i;
  assign busy_o         = (state_q != S_IDLE);
  assign pend_valid_o   = pend_valid_q;
  assign pend_is_data_o = pend_data_q;
  assign pend_way_o     = pend_way_q;
  assign pend_last_o    = pend_last_q;

  // R8
  data_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_is_data_o) |-> cd_q);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(index_q));
endmodule

// File: rtl/icache_parity_scrubber.sv
module icache_parity_scrubber #(
  parameter int WAYS      = 4,
  parameter int LINE_DW   = 4,
  parameter int IDX_W     = 13,
  parameter int OFF_SHIFT = 3,
  parameter int HI_W      = 32,
  parameter int LO_W      = 64,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int ADDR_W   = IDX_W + WAY_W,
  localparam int LRU_W    = WAYS * WAY_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [IDX_W-1:0]        index_i,
  input  logic                    check_data_i,
  output logic                    rd_req_o,
  output logic                    rd_is_data_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic [HI_W-1:0]         rd_hi_i,
  input  logic [LO_W-1:0]         rd_lo_i,
  output logic [WAYS-1:0]         way_tag_err_o,
  output logic [WAYS-1:0]         way_data_err_o,
  output logic [LRU_W-1:0]        lru_order_o,
  output logic                    done_o,
  output logic [ips_pkg::RES_W-1:0] result_o
);
  import ips_pkg::*;

  logic             rst_s;
  logic             accept;
  logic             busy;
  logic             pend_valid;
  logic             pend_is_data;
  logic [WAY_W-1:0] pend_way;
  logic             pend_last;
  logic             tag_err;
  logic             data_err;

  logic [WAYS-1:0]  way_tag_q, way_tag_d;
  logic [WAYS-1:0]  way_data_q, way_data_d;
  logic [LRU_W-1:0] lru_q, lru_d;
  logic             res_tag_q, res_tag_d;
  logic             res_data_q, res_data_d;
  logic             done_q, done_d;
  logic             acc_en;

  ips_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_s)
  );

  ips_seq #(
    .WAYS      (WAYS),
    .LINE_DW   (LINE_DW),
    .IDX_W     (IDX_W),
    .OFF_SHIFT (OFF_SHIFT)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_s),
    .start_i        (start_i),
    .index_i        (index_i),
    .check_data_i   (check_data_i),
    .rd_req_o       (rd_req_o),
    .rd_is_data_o   (rd_is_data_o),
    .rd_addr_o      (rd_addr_o),
    .accept_o       (accept),
    .busy_o         (busy),
    .pend_valid_o   (pend_valid),
    .pend_is_data_o (pend_is_data),
    .pend_way_o     (pend_way),
    .pend_last_o    (pend_last)
  );

  ips_tag_check #(.HI_W(HI_W), .LO_W(LO_W)) u_tag (
    .hi_i  (rd_hi_i),
    .lo_i  (rd_lo_i),
    .err_o (tag_err)
  );

  ips_data_check #(.HI_W(HI_W), .LO_W(LO_W)) u_data (
    .hi_i  (rd_hi_i),
    .lo_i  (rd_lo_i),
    .err_o (data_err)
  );

  always_comb begin
    way_tag_d  = way_tag_q;
    way_data_d = way_data_q;
    lru_d      = lru_q;
    res_tag_d  = res_tag_q;
    res_data_d = res_data_q;
    done_d     = 1'b0;
    if (accept) begin
      way_tag_d  = '0;
      way_data_d = '0;
      lru_d      = '0;
      res_tag_d  = 1'b0;
      res_data_d = 1'b0;
    end else if (pend_valid) begin
      done_d = pend_last;
      if (pend_is_data) begin
        way_data_d[pend_way] = way_data_q[pend_way] | data_err;
        res_data_d           = res_data_q | data_err;
      end else begin
        way_tag_d[pend_way] = way_tag_q[pend_way] | tag_err;
        res_tag_d           = res_tag_q | tag_err;
        if (pend_way == '0) lru_d = rd_hi_i[LRU_LSB +: LRU_W];
      end
    end
  end

  assign acc_en = accept || pend_valid;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      way_tag_q  <= '0;
      way_data_q <= '0;
      lru_q      <= '0;
      res_tag_q  <= 1'b0;
      res_data_q <= 1'b0;
    end else if (acc_en) begin
      way_tag_q  <= way_tag_d;
      way_data_q <= way_data_d;
      lru_q      <= lru_d;
      res_tag_q  <= res_tag_d;
      res_data_q <= res_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_comb begin
    result_o               = '0;
    result_o[RES_TAG_BIT]  = res_tag_q;
    result_o[RES_DATA_BIT] = res_data_q;
  end

  assign way_tag_err_o  = way_tag_q;
  assign way_data_err_o = way_data_q;
  assign lru_order_o    = lru_q;
  assign done_o         = done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |=> !done_q);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy && !start_i) |=> ($stable(result_o) && $stable(way_tag_q) &&
                             $stable(way_data_q) && $stable(lru_q)));

  // R6
  flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |-> ((res_tag_q == (|way_tag_q)) && (res_data_q == (|way_data_q))));
endmodule

// File: tb/icache_parity_scrubber_test.sv
`timescale 1ns/1ps
module icache_parity_scrubber_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [12:0] index;
  logic        check_data;
  logic        rd_req;
  logic        rd_is_data;
  logic [14:0] rd_addr;
  logic [31:0] rd_hi;
  logic [63:0] rd_lo;
  logic [3:0]  way_tag_err;
  logic [3:0]  way_data_err;
  logic [7:0]  lru_order;
  logic        done;
  logic [31:0] result;

  icache_parity_scrubber uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .index_i        (index),
    .check_data_i   (check_data),
    .rd_req_o       (rd_req),
    .rd_is_data_o   (rd_is_data),
    .rd_addr_o      (rd_addr),
    .rd_hi_i        (rd_hi),
    .rd_lo_i        (rd_lo),
    .way_tag_err_o  (way_tag_err),
    .way_data_err_o (way_data_err),
    .lru_order_o    (lru_order),
    .done_o         (done),
    .result_o       (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [12:0] IDX_A = 13'h1A60;
  localparam logic [12:0] IDX_B = 13'h0C80;

  logic [31:0] thi [4];
  logic [63:0] tlo [4];
  logic [31:0] dhi [4][4];
  logic [63:0] dlo [4][4];
  logic [14:0] alog [256];
  logic        dlog [256];
  int          nlog;
  int          n_data;
  int          checks;
  int          fails;
  bit          finished;

  initial begin
    nlog   = 0;
    n_data = 0;
  end

  always @(posedge clk) begin
    if (rd_req) begin
      alog[nlog[7:0]] <= rd_addr;
      dlog[nlog[7:0]] <= rd_is_data;
      nlog            <= nlog + 1;
      if (rd_is_data) begin
        n_data <= n_data + 1;
        rd_hi  <= dhi[rd_addr[14:13]][rd_addr[4:3]];
        rd_lo  <= dlo[rd_addr[14:13]][rd_addr[4:3]];
      end else begin
        rd_hi <= thi[rd_addr[14:13]];
        rd_lo <= tlo[rd_addr[14:13]];
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [3:0] bpar(input logic [31:0] x);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = ^x[8*b +: 8];
    return r;
  endfunction

  task automatic fix_tag(input int w);
    thi[w][27] = thi[w][29];
    tlo[w][10] = ^(tlo[w][23:0] & 24'hFFF3FF);
    tlo[w][11] = ^tlo[w][63:24];
  endtask

  task automatic fix_data(input int w, input int o);
    dhi[w][o][16]  = ^dhi[w][o][15:8];
    dhi[w][o][7:4] = bpar(dlo[w][o][63:32]);
    dhi[w][o][3:0] = bpar(dlo[w][o][31:0]);
  endtask

  task automatic init_mem();
    for (int w = 0; w < 4; w++) begin
      thi[w] = 32'h1234_5678 ^ (32'(w) * 32'h0F0F_1111);
      thi[w][29] = 1'b1;
      thi[w][21:14] = (w == 0) ? 8'h4E : (8'h1B ^ 8'(w));
      tlo[w] = 64'h0123_4567_89AB_CDEF * 64'(w + 3);
      fix_tag(w);
      for (int o = 0; o < 4; o++) begin
        dlo[w][o] = {32'hA5C3_0000 + 32'(w * 16 + o), 32'h3C5A_1000 ^ 32'(o * 977 + w)};
        dhi[w][o] = 32'h0000_A700 ^ 32'(w * 256 + o * 4096);
        fix_data(w, o);
      end
    end
  endtask

  // Runs one walk; returns the falling-edge count at which done was seen.
  task automatic run_scan(input logic cd, input bit poke, output int cnt);
    @(negedge clk);
    index      = IDX_A;
    check_data = cd;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt   = 1;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 3) begin
        start = 1'b1;
        index = IDX_B;
      end
      if (poke && cnt == 4) start = 1'b0;
    end
  endtask

  task automatic check_addrs(input string tag, input int base, input logic cd);
    int nbad;
    int k;
    nbad = 0;
    k    = base;
    for (int w = 0; w < 4; w++) begin
      if (alog[k[7:0]] !== {w[1:0], IDX_A} || dlog[k[7:0]] !== 1'b0) nbad++;
      k++;
      if (cd) begin
        for (int o = 0; o < 4; o++) begin
          if (alog[k[7:0]] !== {w[1:0], IDX_A | (13'(o) << 3)} || dlog[k[7:0]] !== 1'b1)
            nbad++;
          k++;
        end
      end
    end
    chk({tag, " address sequence mismatches"}, nbad, 0);
    chk({tag, " read count"}, nlog - base, cd ? 20 : 4);
  endtask

  task automatic t_reset();
    chk("R9 reset done", {31'd0, done}, 0);
    chk("R6 reset result", result, 0);
    chk("R1 reset rd_req", {31'd0, rd_req}, 0);
  endtask

  task automatic t_clean();
    int cnt, base, nd;
    init_mem();
    base = nlog;
    nd   = n_data;
    run_scan(1'b1, 1'b0, cnt);
    chk("R9 done timing with data", cnt, 22);
    check_addrs("R1 clean", base, 1'b1);
    chk("R1 data reads", n_data - nd, 16);
    chk("R6 clean result", result, 0);
    chk("R6 clean flags", {24'd0, way_tag_err, way_data_err}, 0);
    chk("R7 lru order", {24'd0, lru_order}, 32'h4E);
  endtask

  task automatic t_tag_split();
    int cnt;
    init_mem();
    tlo[2][10] = ~tlo[2][10];
    run_scan(1'b1, 1'b0, cnt);
    chk("R3 low-half tag parity result", result, 32'h2000_0000);
    chk("R3 low-half tag flags", {28'd0, way_tag_err}, 32'h4);
    init_mem();
    tlo[1][40] = ~tlo[1][40];
    run_scan(1'b1, 1'b0, cnt);
    chk("R3 high-half tag flags", {28'd0, way_tag_err}, 32'h2);
    chk("R6 no data flag on tag fault", {28'd0, way_data_err}, 0);
    init_mem();
    tlo[0][5] = ~tlo[0][5];
    fix_tag(0);
    tlo[0][10] = ~tlo[0][10];
    tlo[0][11] = ~tlo[0][11];
    tlo[0][11] = ~tlo[0][11];
    run_scan(1'b1, 1'b0, cnt);
    chk("R3 masked parity bits excluded", {28'd0, way_tag_err}, 32'h1);
  endtask

  task automatic t_valid();
    int cnt;
    init_mem();
    thi[3][29] = 1'b0;
    thi[3][27] = 1'b0;
    tlo[3][10] = ~tlo[3][10];
    tlo[3][11] = ~tlo[3][11];
    run_scan(1'b1, 1'b0, cnt);
    chk("R3 invalid line split parity ignored", result, 0);
    init_mem();
    thi[3][29] = 1'b0;
    thi[3][27] = 1'b1;
    run_scan(1'b1, 1'b0, cnt);
    chk("R2 invalid line valid-copy mismatch", {28'd0, way_tag_err}, 32'h8);
    chk("R2 result", result, 32'h2000_0000);
    init_mem();
    thi[0][27] = 1'b0;
    run_scan(1'b1, 1'b0, cnt);
    chk("R2 valid line copy mismatch", {28'd0, way_tag_err}, 32'h1);
  endtask

  task automatic t_predecode();
    int cnt;
    init_mem();
    dhi[3][2][16] = ~dhi[3][2][16];
    run_scan(1'b1, 1'b0, cnt);
    chk("R4 predecode result", result, 32'h1000_0000);
    chk("R4 predecode flags", {28'd0, way_data_err}, 32'h8);
    chk("R4 no tag flag", {28'd0, way_tag_err}, 0);
  endtask

  task automatic t_inst();
    int cnt;
    init_mem();
    dhi[0][0][7] = ~dhi[0][0][7];
    dlo[1][3][0] = ~dlo[1][3][0];
    tlo[2][30]   = ~tlo[2][30];
    run_scan(1'b1, 1'b0, cnt);
    chk("R5 instruction parity flags", {28'd0, way_data_err}, 32'h3);
    chk("R6 combined result", result, 32'h3000_0000);
    chk("R6 combined tag flags", {28'd0, way_tag_err}, 32'h4);
    init_mem();
    dlo[2][1][63] = ~dlo[2][1][63];
    run_scan(1'b1, 1'b0, cnt);
    chk("R5 top byte of instruction A", {28'd0, way_data_err}, 32'h4);
  endtask

  task automatic t_nodata();
    int cnt, base, nd;
    init_mem();
    dhi[1][2][16] = ~dhi[1][2][16];
    dlo[3][0][9]  = ~dlo[3][0][9];
    base = nlog;
    nd   = n_data;
    run_scan(1'b0, 1'b0, cnt);
    chk("R9 done timing without data", cnt, 6);
    chk("R8 data reads skipped", n_data - nd, 0);
    check_addrs("R8 tag-only", base, 1'b0);
    chk("R8 data fault not reported", result, 0);
  endtask

  task automatic t_lru();
    int cnt;
    init_mem();
    thi[0][21:14] = 8'hE4;
    fix_tag(0);
    thi[3][21:14] = 8'h00;
    fix_tag(3);
    run_scan(1'b1, 1'b0, cnt);
    chk("R7 lru from way 0 only", {24'd0, lru_order}, 32'hE4);
  endtask

  task automatic t_hold();
    int cnt, base;
    init_mem();
    tlo[1][10] = ~tlo[1][10];
    base = nlog;
    run_scan(1'b1, 1'b1, cnt);
    chk("R9 start during walk ignored, timing", cnt, 22);
    check_addrs("R9 start during walk", base, 1'b1);
    chk("R9 result after walk", result, 32'h2000_0000);
    init_mem();
    base = nlog;
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk("R9 result held", result, 32'h2000_0000);
    chk("R9 flags held", {28'd0, way_tag_err}, 32'h2);
    chk("R9 done low when idle", {31'd0, done}, 0);
    chk("R9 no reads when idle", nlog - base, 0);
  endtask

  initial begin
    checks     = 0;
    fails      = 0;
    finished   = 1'b0;
    rst_n      = 1'b0;
    start      = 1'b0;
    index      = '0;
    check_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean();
    t_tag_split();
    t_valid();
    t_predecode();
    t_inst();
    t_nodata();
    t_lru();
    t_hold();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule